// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block follows a linked list of 16-byte data descriptors held in memory and turns each one into a single burst request for a downstream data mover. A sequencer hands over the address of the first descriptor with a one-cycle start pulse. The walker reads the descriptor as four 32-bit words through a simple request/response memory port. It decodes the buffer address, the length, the direction, the ordering and the transfer-mode fields. It presents them as one burst and waits until the burst is taken. It then follows the next pointer until it reaches the entry flagged as the final one.

The walk ends with a one-cycle done pulse, or with a one-cycle error pulse and a cause code. An error is raised when the chain is inconsistent: a misaligned pointer, or more entries than the configured ceiling. The ceiling stops a chain that loops back on itself. Moving the data itself lies outside this block.

Top module: `sg_chain_walker`

## Requirements
- R1: A descriptor at pointer P is read as four word reads at P, P+4, P+8 and P+12, issued in that order with at most one read outstanding. Each response word is taken little-endian: word 0 is the buffer address, word 1 is the length in 8-byte units, word 2 bits [7:0] are the flags and bits [11:8] are the transfer mode, and word 3 is the next pointer.
- R2: Each burst carries the buffer address from word 0, a byte count equal to the length field times 8, write = flag bit 5, ordered = flag bit 4, and mode = word 2 bits [11:8]. Other flag and mode bits have no effect.
- R3: Once burst_valid rises, it and all burst fields hold steady until burst_ready is seen. No memory read is issued while a burst is pending.
- R4: A descriptor whose length field is zero produces no burst, and the walk continues with its next pointer.
- R5: After the descriptor with flag bit 7 set has had its burst accepted (or has been skipped, if its length is zero), done pulses for one cycle. That descriptor's next pointer is neither read nor checked, even when it is misaligned.
- R6: A start pointer, or the next pointer of a descriptor that is not the last one, with any of its low 3 bits set ends the walk with an error pulse and err_code = 1. No read is made at that pointer.
- R7: If descriptor number MAX_ENTRIES of a walk is not the last one, the walk ends with an error pulse and err_code = 2 once that descriptor has been handled. A walk therefore never issues more than MAX_ENTRIES bursts.
- R8: busy is high from an accepted start until the cycle in which done or err pulses. A start pulse while busy has no effect on the walk in progress.
- R9: During and after reset, busy, done, err, mem_req_valid and burst_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a walk when idle |
| start_ptr | input | 32 | Address of the first descriptor |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: chain finished cleanly |
| err | output | 1 | One-cycle pulse: walk aborted |
| err_code | output | 2 | Cause of the last abort: 1 misaligned pointer, 2 entry ceiling |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Read data |
| burst_valid | output | 1 | Burst request pending |
| burst_ready | input | 1 | Data mover takes the burst |
| burst_addr | output | 32 | Buffer start address |
| burst_bytes | output | 35 | Burst length in bytes |
| burst_write | output | 1 | 1 = data goes out to the device |
| burst_ordered | output | 1 | In-order handling requested |
| burst_mode | output | 4 | Transfer mode for the burst |

## Verification
The hardest case to reach from the ports is the entry ceiling. A chain must stay consistent for exactly MAX_ENTRIES descriptors and still not end. The stimulus builds this with a descriptor whose next pointer points to itself, and separately with a chain of exactly MAX_ENTRIES entries whose final one is flagged as the last, so that both sides of the boundary are seen. The random chains use random memory latency and random ready on both handshakes. They place junk in the ignored flag and mode bits and in the final entry's next pointer, so the hold rules and the ignored fields are exercised under back-pressure.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int ADDR_W  = 32;
  localparam int LEN_W   = 32;
  localparam int UNIT_SH = 3;
  localparam int BYTES_W = LEN_W + UNIT_SH;
  localparam int MODE_W  = 4;

  localparam int FLAG_ORD  = 4;
  localparam int FLAG_OUT  = 5;
  localparam int FLAG_LAST = 7;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_ALIGN = 2'd1,
    ERR_LIMIT = 2'd2
  } sgw_err_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_BURST,
    ST_NEXT
  } sgw_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic              last;
    logic              out_dir;
    logic              ordered;
    logic [MODE_W-1:0] mode;
    logic [ADDR_W-1:0] next;
  } sgw_desc_t;
endpackage

// File: rtl/sgw_desc_fetch.sv
module sgw_desc_fetch
  import sgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              desc_valid,
  output sgw_desc_t         desc
);
  localparam int WORDS = 4;
  localparam int IDX_W = $clog2(WORDS);

  logic              active_q, active_d;
  logic              wait_q, wait_d;
  logic              dv_q, dv_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [31:0]       word_q [WORDS];

  always_comb begin
    active_d = active_q;
    wait_d   = wait_q;
    idx_d    = idx_q;
    base_d   = base_q;
    dv_d     = 1'b0;
    if (go) begin
      active_d = 1'b1;
      wait_d   = 1'b0;
      idx_d    = '0;
      base_d   = go_base;
    end else if (active_q) begin
      if (!wait_q) begin
        if (mem_req_ready) wait_d = 1'b1;
      end else if (mem_rsp_valid) begin
        wait_d = 1'b0;
        if (idx_q == IDX_W'(WORDS - 1)) begin
          active_d = 1'b0;
          dv_d     = 1'b1;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wait_q   <= 1'b0;
      dv_q     <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
    end else begin
      active_q <= active_d;
      wait_q   <= wait_d;
      dv_q     <= dv_d;
      idx_q    <= idx_d;
      base_q   <= base_d;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic cap;
    assign cap = wait_q && mem_rsp_valid && (idx_q == IDX_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[w] <= '0;
      else if (cap) word_q[w] <= mem_rsp_data;
    end
  end

  assign mem_req_valid = active_q && !wait_q;
  assign mem_req_addr  = base_q + {{(ADDR_W-IDX_W-2){1'b0}}, idx_q, 2'b00};
  assign desc_valid    = dv_q;

  assign desc.addr    = word_q[0];
  assign desc.len     = word_q[1];
  assign desc.last    = word_q[2][FLAG_LAST];
  assign desc.out_dir = word_q[2][FLAG_OUT];
  assign desc.ordered = word_q[2][FLAG_ORD];
  assign desc.mode    = word_q[2][8 +: MODE_W];
  assign desc.next    = word_q[3];

  logic unused_flag_bits;
  assign unused_flag_bits = ^{word_q[2][31:12], word_q[2][6], word_q[2][3:0]};
endmodule

// File: rtl/sgw_walk_ctrl.sv
module sgw_walk_ctrl
  import sgw_pkg::*;
#(
  parameter int MAX_ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_ptr,
  input  logic              desc_valid,
  input  logic              desc_len_nz,
  input  logic              desc_last,
  input  logic [ADDR_W-1:0] desc_next,
  input  logic              burst_ready,
  output logic              fetch_go,
  output logic [ADDR_W-1:0] fetch_base,
  output logic              burst_valid,
  output logic              busy,
  output logic              done,
  output logic              err,
  output sgw_err_e          err_code
);
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1);

  sgw_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d, err_q, err_d;
  sgw_err_e         code_q, code_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    done_d     = 1'b0;
    err_d      = 1'b0;
    code_d     = code_q;
    fetch_go   = 1'b0;
    fetch_base = desc_next;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (|start_ptr[UNIT_SH-1:0]) begin
            err_d  = 1'b1;
            code_d = ERR_ALIGN;
          end else begin
            fetch_go   = 1'b1;
            fetch_base = start_ptr;
            cnt_d      = CNT_W'(1);
            code_d     = ERR_NONE;
            state_d    = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (desc_valid) state_d = desc_len_nz ? ST_BURST : ST_NEXT;
      end
      ST_BURST: begin
        if (burst_ready) state_d = ST_NEXT;
      end
      ST_NEXT: begin
        state_d = ST_IDLE;
        if (desc_last) begin
          done_d = 1'b1;
        end else if (|desc_next[UNIT_SH-1:0]) begin
          err_d  = 1'b1;
          code_d = ERR_ALIGN;
        end else if (cnt_q == CNT_W'(MAX_ENTRIES)) begin
          err_d  = 1'b1;
          code_d = ERR_LIMIT;
        end else begin
          fetch_go = 1'b1;
          cnt_d    = cnt_q + CNT_W'(1);
          state_d  = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= ERR_NONE;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      err_q   <= err_d;
      code_q  <= code_d;
    end
  end

  assign burst_valid = (state_q == ST_BURST);
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign err         = err_q;
  assign err_code    = code_q;
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
  import sgw_pkg::*;
#(
  parameter int MAX_ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_ptr,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [1:0]         err_code,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rsp_data,
  output logic               burst_valid,
  input  logic               burst_ready,
  output logic [ADDR_W-1:0]  burst_addr,
  output logic [BYTES_W-1:0] burst_bytes,
  output logic               burst_write,
  output logic               burst_ordered,
  output logic [MODE_W-1:0]  burst_mode
);
  logic              fetch_go;
  logic [ADDR_W-1:0] fetch_base;
  logic              desc_valid;
  sgw_desc_t         desc;
  sgw_err_e          code;

  sgw_desc_fetch u_fetch (
    .clk           (clk),
    .rst_n         (rst_n),
    .go            (fetch_go),
    .go_base       (fetch_base),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .desc_valid    (desc_valid),
    .desc          (desc)
  );

  sgw_walk_ctrl #(.MAX_ENTRIES(MAX_ENTRIES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_ptr   (start_ptr),
    .desc_valid  (desc_valid),
    .desc_len_nz (|desc.len),
    .desc_last   (desc.last),
    .desc_next   (desc.next),
    .burst_ready (burst_ready),
    .fetch_go    (fetch_go),
    .fetch_base  (fetch_base),
    .burst_valid (burst_valid),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .err_code    (code)
  );

  assign err_code      = code;
  assign burst_addr    = desc.addr;
  assign burst_bytes   = {desc.len, {UNIT_SH{1'b0}}};
  assign burst_write   = desc.out_dir;
  assign burst_ordered = desc.ordered;
  assign burst_mode    = desc.mode;
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker
  import sgw_pkg::*;
#(
  parameter int MAX_ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               err,
  input logic [1:0]         err_code,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [ADDR_W-1:0]  mem_req_addr,
  input logic               burst_valid,
  input logic               burst_ready,
  input logic [ADDR_W-1:0]  burst_addr,
  input logic [BYTES_W-1:0] burst_bytes,
  input logic               burst_write,
  input logic               burst_ordered,
  input logic [MODE_W-1:0]  burst_mode
);
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1);

  logic [CNT_W:0] n_bursts;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         n_bursts <= '0;
    else if (start && !busy)            n_bursts <= '0;
    else if (burst_valid && burst_ready) n_bursts <= n_bursts + (CNT_W+1)'(1);
  end

  assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_req_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  assert_burst_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && !burst_ready) |=> (burst_valid && $stable(burst_addr) &&
      $stable(burst_bytes) && $stable(burst_write) && $stable(burst_ordered) &&
      $stable(burst_mode)));

  assert_no_read_in_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(burst_valid && mem_req_valid));

  assert_done_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_err_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (err_code != 2'd0));

  assert_burst_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && burst_ready) |-> (n_bursts < (CNT_W+1)'(MAX_ENTRIES)));
endmodule

bind sg_chain_walker sgw_checker #(.MAX_ENTRIES(MAX_ENTRIES)) u_sgw_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .busy          (busy),
  .done          (done),
  .err           (err),
  .err_code      (err_code),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .burst_valid   (burst_valid),
  .burst_ready   (burst_ready),
  .burst_addr    (burst_addr),
  .burst_bytes   (burst_bytes),
  .burst_write   (burst_write),
  .burst_ordered (burst_ordered),
  .burst_mode    (burst_mode)
);

// File: tb/sg_chain_walker_tb.sv
`timescale 1ns/1ps
module sg_chain_walker_tb;
  localparam int MAXE = 8;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] start_ptr;
  logic        busy, done, err;
  logic [1:0]  err_code;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        burst_valid, burst_ready;
  logic [31:0] burst_addr;
  logic [34:0] burst_bytes;
  logic        burst_write, burst_ordered;
  logic [3:0]  burst_mode;

  sg_chain_walker #(.MAX_ENTRIES(MAXE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
    .busy(busy), .done(done), .err(err), .err_code(err_code),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .burst_valid(burst_valid),
    .burst_ready(burst_ready), .burst_addr(burst_addr),
    .burst_bytes(burst_bytes), .burst_write(burst_write),
    .burst_ordered(burst_ordered), .burst_mode(burst_mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          finished = 1'b0;

  logic [31:0] mem [0:255];

  logic [31:0] exp_req   [0:63];
  logic [31:0] exp_baddr [0:63];
  logic [34:0] exp_bytes [0:63];
  logic [5:0]  exp_battr [0:63];
  int          n_exp_req, n_exp_burst;
  logic [1:0]  exp_code;

  int          n_req, n_burst;
  bit          got_end;
  logic [1:0]  got_code;

  bit          pend;
  int          dly;
  logic [31:0] paddr;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[9:2]];
  endfunction

  // Reference walk computed from the requirements
  task automatic build_expect(input logic [31:0] p);
    logic [31:0] ptr, w0, w1, w2, w3;
    int cnt;
    bit stop;
    n_exp_req = 0; n_exp_burst = 0; exp_code = 2'd0;
    ptr = p; cnt = 0; stop = 1'b0;
    if (p[2:0] != 3'd0) begin
      exp_code = 2'd1;
      stop = 1'b1;
    end
    while (!stop) begin
      cnt++;
      for (int w = 0; w < 4; w++) begin
        exp_req[n_exp_req] = ptr + 32'(4*w);
        n_exp_req++;
      end
      w0 = rd(ptr); w1 = rd(ptr+4); w2 = rd(ptr+8); w3 = rd(ptr+12);
      if (w1 != 32'd0) begin
        exp_baddr[n_exp_burst] = w0;
        exp_bytes[n_exp_burst] = {w1, 3'b000};
        exp_battr[n_exp_burst] = {w2[5], w2[4], w2[11:8]};
        n_exp_burst++;
      end
      if (w2[7]) stop = 1'b1;
      else if (w3[2:0] != 3'd0) begin exp_code = 2'd1; stop = 1'b1; end
      else if (cnt == MAXE) begin exp_code = 2'd2; stop = 1'b1; end
      else ptr = w3;
    end
  endtask

  task automatic put_desc(input int slot, input logic [31:0] a, input logic [31:0] len,
                          input logic [31:0] attr, input logic [31:0] nxt);
    mem[slot*4+0] = a;
    mem[slot*4+1] = len;
    mem[slot*4+2] = attr;
    mem[slot*4+3] = nxt;
  endtask

  // Memory model and burst sink, driven between clock edges
  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    burst_ready = 1'b0; pend = 1'b0; dly = 0; paddr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(paddr);
          pend = 1'b0;
        end else dly--;
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (n_req < n_exp_req)
          chk(mem_req_addr == exp_req[n_req], "R1 read address", mem_req_addr, exp_req[n_req]);
        else
          chk(1'b0, "R1/R6 unexpected read", mem_req_addr, 64'd0);
        n_req++;
        pend  = 1'b1;
        paddr = mem_req_addr;
        dly   = $urandom % 3;
      end
      burst_ready = ($urandom % 3) != 0;
      if (rst_n && burst_valid && burst_ready) begin
        if (n_burst < n_exp_burst) begin
          chk(burst_addr == exp_baddr[n_burst], "R2 burst address", burst_addr, exp_baddr[n_burst]);
          chk(burst_bytes == exp_bytes[n_burst], "R2 burst bytes", burst_bytes, exp_bytes[n_burst]);
          chk({burst_write, burst_ordered, burst_mode} == exp_battr[n_burst], "R2 burst attributes",
              {burst_write, burst_ordered, burst_mode}, exp_battr[n_burst]);
        end else
          chk(1'b0, "R4/R7 unexpected burst", burst_addr, 64'd0);
        n_burst++;
      end
      if (rst_n && (done || err) && !got_end) begin
        got_end  = 1'b1;
        got_code = done ? 2'd0 : err_code;
      end
    end
  end

  task automatic run_walk(input logic [31:0] p, input string tag, input bit poke,
                          input logic [31:0] poke_ptr);
    int waited;
    build_expect(p);
    n_req = 0; n_burst = 0; got_end = 1'b0; got_code = 2'd3;
    @(negedge clk);
    start = 1'b1; start_ptr = p;
    @(negedge clk);
    start = 1'b0;
    if (p[2:0] == 3'd0) chk(busy == 1'b1, "R8 busy after start", busy, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      chk(busy == 1'b1, "R8 busy before second start", busy, 1);
      start = 1'b1; start_ptr = poke_ptr;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!got_end && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    chk(got_end, {tag, " walk ended"}, got_end, 1);
    chk(got_code == exp_code, {tag, " outcome code"}, got_code, exp_code);
    chk(n_req == n_exp_req, {tag, " read count"}, n_req, n_exp_req);
    chk(n_burst == n_exp_burst, {tag, " burst count"}, n_burst, n_exp_burst);
    chk(busy == 1'b0, "R8 idle after end", busy, 0);
  endtask

  // Random chain of n entries at slots b, b+7, ...; the final entry gets a junk next pointer
  task automatic make_chain(input int b, input int n);
    int s, sn;
    logic [31:0] len, attr;
    for (int i = 0; i < n; i++) begin
      s  = (b + 7*i) % 64;
      sn = (b + 7*(i+1)) % 64;
      len = ($urandom % 4 == 0) ? 32'd0 : (($urandom % 8 == 0) ? $urandom : ($urandom % 5000));
      attr = $urandom & 32'hFFFF_FF7F;
      if (i == n-1) put_desc(s, $urandom, len, attr | 32'h80, $urandom);
      else          put_desc(s, $urandom, len, attr, 32'(sn*16));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    n_exp_req = 0; n_exp_burst = 0; exp_code = 0;
    n_req = 0; n_burst = 0; got_end = 0; got_code = 0;
    rst_n = 1'b0; start = 1'b0; start_ptr = '0;
    repeat (3) @(negedge clk);
    chk({busy, done, err, mem_req_valid, burst_valid} == 5'd0, "R9 outputs in reset",
        {busy, done, err, mem_req_valid, burst_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, done, err, mem_req_valid, burst_valid} == 5'd0, "R9 outputs after reset",
        {busy, done, err, mem_req_valid, burst_valid}, 0);

    // R6: misaligned start pointer, no read at all
    run_walk(32'h0000_0013, "R6 misaligned start", 1'b0, 0);

    // R2: single entry, maximum length, ignored bits set in flags and mode byte
    put_desc(1, 32'hDEAD_BEE8, 32'hFFFF_FFFF, 32'hABCD_F3FF, 32'h0);
    run_walk(32'd16, "R2 max length", 1'b0, 0);

    // R4/R5: single zero-length last entry whose next pointer is misaligned
    put_desc(2, 32'h1234_5678, 32'd0, 32'h0000_0580, 32'h0000_0005);
    run_walk(32'd32, "R4/R5 zero length last", 1'b0, 0);

    // R6: misaligned next pointer in the middle of a chain
    put_desc(10, 32'h0001_0000, 32'd4, 32'h0000_0120, 32'd176);
    put_desc(11, 32'h0002_0000, 32'd0, 32'h0000_0210, 32'd196);
    put_desc(12, 32'h0003_0000, 32'd9, 32'h0000_0080, 32'd0);
    run_walk(32'd160, "R6 misaligned next", 1'b0, 0);

    // R7: descriptor pointing to itself
    put_desc(5, 32'h0000_4000, 32'd3, 32'h0000_0710, 32'd80);
    run_walk(32'd80, "R7 looped chain", 1'b0, 0);

    // R7: exactly MAXE entries, last one flagged
    make_chain(20, MAXE);
    run_walk(32'(20*16), "R7 chain at ceiling", 1'b0, 0);

    // R7: MAXE+1 entries, ceiling hit before the last flag
    make_chain(33, MAXE + 1);
    run_walk(32'(33*16), "R7 chain over ceiling", 1'b0, 0);

    // R8: second start during a walk is ignored
    make_chain(40, 6);
    run_walk(32'(40*16), "R8 start while busy", 1'b1, 32'd16);

    // R1/R2/R3/R4/R5: random chains under random latency and back-pressure
    for (int t = 0; t < 25; t++) begin
      int b;
      b = $urandom % 64;
      make_chain(b, 1 + ($urandom % 6));
      run_walk(32'(b*16), "R1/R3 random chain", 1'b0, 0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule